// File: doc/BRIEF.md
# Pipeline Stage Skid-Buffer Controller

This block governs one in-order pipeline stage for a single thread. Each cycle a group of up to `IN_W` tagged words arrives from upstream. The stage forwards at most `OUT_W` live words downstream in lane order. Words that arrive already killed are discarded and do not use an output slot. Each word carries a flag saying it has no source operands, and that flag is reported as "ready to issue" when the word leaves.

Three downstream stages can hold the stage with block and unblock pulses, which set and clear one sticky flag each. While held, arriving words are captured in a skid buffer. When the hold lifts, the buffer is drained before any fresh word is forwarded directly, and words that arrive during the drain are appended to its tail. Upstream is told by single-cycle block and unblock pulses.

A downstream squash throws everything away. A separate "still squashing" input keeps the stage quiet. The thread's status is one of five states: Idle, Running, Blocked, Unblocking and Squashing.

Top module: `stage_skid_ctrl`

## Requirements
- R1: Reset leaves `state_o` = 0 (Idle), `skid_cnt_o` = 0, `stall_o` = 0 and `skid_ovf_o` = 0. State codes are Idle 0, Running 1, Blocked 2, Unblocking 3, Squashing 4.
- R2: `dn_blk_i[k]` sets stall flag k and `dn_unblk_i[k]` clears it. When both are present in the same cycle, the clear wins. Flags persist between pulses, and in every cycle the stage counts as held if any flag is set once that cycle's pulses have been applied.
- R3: When held, the live input words are appended to the skid buffer, nothing is forwarded, and the next state is Blocked. `up_blk_o` pulses only if the current state is neither Blocked nor Unblocking.
- R4: In Idle, Running or Squashing, the first `OUT_W` live input words, in lane order, are forwarded on output lanes 0 and upward. A lane with `in_kill_i` set is skipped and takes no output slot.
- R5: If more live words arrive than `OUT_W`, the excess words enter the skid buffer, the next state is Blocked and `up_blk_o` pulses.
- R6: In Blocked or Unblocking without a hold, up to `OUT_W` words leave from the head of the skid buffer in order. The live input is appended behind them, none of it is forwarded, and the next state is Unblocking.
- R7: If the skid buffer is empty at the end of such a draining cycle, `up_unblk_o` pulses and the next state is Running.
- R8: `squash_i` has the highest priority. Nothing is forwarded, the skid buffer is emptied, and the next state is Squashing. `up_unblk_o` pulses if the state was Blocked or Unblocking, and `up_blk_o` never pulses in that cycle.
- R9: `squash_hold_i` without `squash_i` forwards nothing, drops the input, and sets the next state to Squashing. It has priority over a hold.
- R10: In Squashing with no squash, hold or stall, the stage behaves as Running in that same cycle, and the next state is Running.
- R11: `out_rdy_o[k]` equals the no-source flag of the word on output lane k, and is 0 on empty lanes.
- R12: `skid_ovf_o` becomes 1 and stays at 1 until reset if a push exceeds the free skid space. The excess words are dropped. With a correct upstream handshake it stays 0.
- R13: Idle moves to Running on the first cycle that forwards a word, and remains Idle in cycles with no live input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | IN_W | Per-lane valid from upstream |
| in_kill_i | input | IN_W | Per-lane already-squashed mark |
| in_nosrc_i | input | IN_W | Per-lane "no source operands" flag |
| in_data_i | input | IN_W*DW | Lane payloads, lane 0 in the low bits |
| dn_blk_i | input | 3 | Block pulse from each downstream stage |
| dn_unblk_i | input | 3 | Unblock pulse from each downstream stage |
| squash_i | input | 1 | Downstream squash request |
| squash_hold_i | input | 1 | Downstream still squashing |
| out_vld_o | output | OUT_W | Per-lane valid to downstream |
| out_rdy_o | output | OUT_W | Per-lane ready-to-issue flag |
| out_data_o | output | OUT_W*DW | Forwarded payloads |
| up_blk_o | output | 1 | Block pulse to upstream |
| up_unblk_o | output | 1 | Unblock pulse to upstream |
| state_o | output | 3 | Current thread state |
| stall_o | output | 3 | Sticky stall flags |
| skid_cnt_o | output | $clog2(SKID_DEPTH+1) | Skid buffer occupancy |
| skid_ovf_o | output | 1 | Sticky overflow error |

## Verification
Three pairs of events can fall in the same cycle:
- A stall flag can be set and cleared in one cycle. The bench pulses block and unblock together on a flag that is already set and expects the stage to drain rather than hold.
- A squash can arrive together with a new block pulse. The bench expects no upstream block pulse in that cycle and a block pulse on the following cycle, when the flag takes effect.
- Fresh input can arrive while the skid buffer drains. The bench follows the order of the words across cycles and expects head words to leave before the appended input.

// File: rtl/stage_skid_pkg.sv
package stage_skid_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_BLK   = 3'd2,
    ST_UNBLK = 3'd3,
    ST_SQ    = 3'd4
  } stage_st_e;

  localparam int unsigned NUM_DN = 3;

  function automatic int unsigned umin(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/stage_skid_flags.sv
module stage_skid_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o,
  output logic         stalled_o
);

  logic [N-1:0] flags_q, flags_d;

  // clear beats set within one cycle
  assign flags_d   = (flags_q | set_i) & ~clr_i;
  assign stalled_o = |flags_d;
  assign flags_o   = flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  a_r2_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & ~clr_i)) |=> ((flags_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

  a_r2_clr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((flags_q & $past(clr_i)) == '0));

endmodule

// File: rtl/stage_skid_pack.sv
module stage_skid_pack #(
  parameter int unsigned LANES = 4,
  parameter int unsigned EW    = 33,
  localparam int unsigned NW   = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] vld_i,
  input  logic [LANES-1:0] kill_i,
  input  logic [EW-1:0]    ent_i [LANES],
  output logic [EW-1:0]    ent_o [LANES],
  output logic [NW-1:0]    live_n_o
);

  // compact live lanes to the low slots, keeping lane order
  always_comb begin
    int unsigned n;
    n = 0;
    for (int k = 0; k < int'(LANES); k++) ent_o[k] = '0;
    for (int j = 0; j < int'(LANES); j++) begin
      if (vld_i[j] && !kill_i[j]) begin
        for (int k = 0; k < int'(LANES); k++)
          if (int'(n) == k) ent_o[k] = ent_i[j];
        n = n + 1;
      end
    end
    live_n_o = NW'(n);
  end

endmodule

// File: rtl/stage_skid_fifo.sv
module stage_skid_fifo #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned EW     = 33,
  parameter int unsigned PUSH_W = 4,
  parameter int unsigned POP_W  = 4,
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned PSW   = $clog2(PUSH_W + 1),
  localparam int unsigned POW   = $clog2(POP_W + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic [PSW-1:0] push_n_i,
  input  logic [EW-1:0]  push_d_i [PUSH_W],
  input  logic [POW-1:0] pop_n_i,
  output logic [EW-1:0]  head_d_o [POP_W],
  output logic [CW-1:0]  cnt_o,
  output logic           ovf_o
);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  int unsigned   acc_n, free_n;

  function automatic logic [PW-1:0] adv(logic [PW-1:0] p, int unsigned n);
    int unsigned s;
    s = int'(p) + n;
    return PW'((s >= DEPTH) ? s - DEPTH : s);
  endfunction

  always_comb begin
    free_n = DEPTH - int'(cnt_q) + int'(pop_n_i);
    acc_n  = stage_skid_pkg::umin(int'(push_n_i), free_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (!clr_i && int'(push_n_i) > free_n) ovf_q <= 1'b1;
      if (clr_i) begin
        rd_q  <= '0;
        wr_q  <= '0;
        cnt_q <= '0;
      end else begin
        rd_q  <= adv(rd_q, int'(pop_n_i));
        wr_q  <= adv(wr_q, acc_n);
        cnt_q <= CW'(int'(cnt_q) - int'(pop_n_i) + acc_n);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int j = 0; j < int'(PUSH_W); j++)
      if (!clr_i && j < int'(acc_n)) mem[adv(wr_q, j)] <= push_d_i[j];
  end

  always_comb
    for (int k = 0; k < int'(POP_W); k++) head_d_o[k] = mem[adv(rd_q, k)];

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  a_r6_pop_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_n_i) <= int'(cnt_q));

  a_r8_clr_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

  a_r12_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);

endmodule

// File: rtl/stage_skid_ctrl.sv
module stage_skid_ctrl
  import stage_skid_pkg::*;
#(
  parameter int unsigned IN_W       = 4,
  parameter int unsigned OUT_W      = 4,
  parameter int unsigned DW         = 32,
  parameter int unsigned FETCH_DLY  = 1,
  parameter int unsigned SKID_DEPTH = FETCH_DLY * IN_W + OUT_W,
  localparam int unsigned EW        = DW + 1,
  localparam int unsigned CW        = $clog2(SKID_DEPTH + 1),
  localparam int unsigned NW        = $clog2(IN_W + 1),
  localparam int unsigned POW       = $clog2(OUT_W + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IN_W-1:0]      in_vld_i,
  input  logic [IN_W-1:0]      in_kill_i,
  input  logic [IN_W-1:0]      in_nosrc_i,
  input  logic [IN_W*DW-1:0]   in_data_i,
  input  logic [NUM_DN-1:0]    dn_blk_i,
  input  logic [NUM_DN-1:0]    dn_unblk_i,
  input  logic                 squash_i,
  input  logic                 squash_hold_i,
  output logic [OUT_W-1:0]     out_vld_o,
  output logic [OUT_W-1:0]     out_rdy_o,
  output logic [OUT_W*DW-1:0]  out_data_o,
  output logic                 up_blk_o,
  output logic                 up_unblk_o,
  output logic [2:0]           state_o,
  output logic [NUM_DN-1:0]    stall_o,
  output logic [CW-1:0]        skid_cnt_o,
  output logic                 skid_ovf_o
);

  stage_st_e     st_q, st_d;
  logic          stalled;
  logic [EW-1:0] in_ent  [IN_W];
  logic [EW-1:0] c_ent   [IN_W];
  logic [EW-1:0] push_d  [IN_W];
  logic [EW-1:0] head_d  [OUT_W];
  logic [EW-1:0] out_ent [OUT_W];
  logic [NW-1:0] live_n, push_n;
  logic [POW-1:0] pop_n;
  logic          skid_clr;

  for (genvar g = 0; g < IN_W; g++) begin : g_in
    assign in_ent[g] = {in_nosrc_i[g], in_data_i[g*DW +: DW]};
  end

  stage_skid_pack #(.LANES(IN_W), .EW(EW)) u_pack (
    .vld_i    (in_vld_i),
    .kill_i   (in_kill_i),
    .ent_i    (in_ent),
    .ent_o    (c_ent),
    .live_n_o (live_n)
  );

  stage_skid_flags #(.N(NUM_DN)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (dn_blk_i),
    .clr_i     (dn_unblk_i),
    .flags_o   (stall_o),
    .stalled_o (stalled)
  );

  stage_skid_fifo #(.DEPTH(SKID_DEPTH), .EW(EW), .PUSH_W(IN_W), .POP_W(OUT_W)) u_skid (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (skid_clr),
    .push_n_i (push_n),
    .push_d_i (push_d),
    .pop_n_i  (pop_n),
    .head_d_o (head_d),
    .cnt_o    (skid_cnt_o),
    .ovf_o    (skid_ovf_o)
  );

  // evaluation order: squash, hold, stall, drain, run
  always_comb begin
    int unsigned live, cnt, fwd, pop, off, rem;
    logic        from_skid;
    live      = int'(live_n);
    cnt       = int'(skid_cnt_o);
    fwd       = 0;
    pop       = 0;
    off       = 0;
    rem       = 0;
    from_skid = 1'b0;
    st_d      = st_q;
    skid_clr  = 1'b0;
    up_blk_o  = 1'b0;
    up_unblk_o = 1'b0;

    if (squash_i) begin
      skid_clr   = 1'b1;
      st_d       = ST_SQ;
      up_unblk_o = (st_q == ST_BLK) || (st_q == ST_UNBLK);
    end else if (squash_hold_i) begin
      st_d = ST_SQ;
    end else if (stalled) begin
      rem      = live;
      st_d     = ST_BLK;
      up_blk_o = (st_q != ST_BLK) && (st_q != ST_UNBLK);
    end else if (st_q == ST_BLK || st_q == ST_UNBLK) begin
      from_skid = 1'b1;
      pop       = umin(cnt, OUT_W);
      rem       = live;
      if (cnt - pop + live == 0) begin
        st_d       = ST_RUN;
        up_unblk_o = 1'b1;
      end else begin
        st_d = ST_UNBLK;
      end
    end else begin
      fwd = umin(live, OUT_W);
      off = fwd;
      rem = live - fwd;
      if (rem != 0) begin
        st_d     = ST_BLK;
        up_blk_o = 1'b1;
      end else if (fwd != 0 || st_q != ST_IDLE) begin
        st_d = ST_RUN;
      end
    end

    push_n = NW'(rem);
    pop_n  = POW'(pop);

    for (int j = 0; j < int'(IN_W); j++) begin
      push_d[j] = '0;
      for (int k = 0; k < int'(IN_W); k++)
        if (k == j + int'(off)) push_d[j] = c_ent[k];
    end

    for (int k = 0; k < int'(OUT_W); k++) begin
      out_ent[k]   = '0;
      out_vld_o[k] = 1'b0;
      if (from_skid) begin
        if (k < int'(pop)) begin
          out_ent[k]   = head_d[k];
          out_vld_o[k] = 1'b1;
        end
      end else if (k < int'(fwd)) begin
        for (int m = 0; m < int'(IN_W); m++)
          if (m == k) out_ent[k] = c_ent[m];
        out_vld_o[k] = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < OUT_W; g++) begin : g_out
    assign out_data_o[g*DW +: DW] = out_ent[g][DW-1:0];
    assign out_rdy_o[g]           = out_ent[g][DW] & out_vld_o[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  a_r8_squash_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |-> ((out_vld_o == '0) && !up_blk_o));

  a_r8_squash_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> ((skid_cnt_o == '0) && (state_o == ST_SQ)));

  a_r9_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_hold_i && !squash_i) |-> ((out_vld_o == '0) && !up_blk_o && !up_unblk_o));

  a_r3_block_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_blk_o |=> (state_o == ST_BLK));

  a_r7_unblock_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_unblk_o && !squash_i) |=> ((state_o == ST_RUN) && (skid_cnt_o == '0)));

  a_r3_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_blk_o && up_unblk_o));

endmodule

// File: tb/stage_skid_ctrl_test.sv
module stage_skid_ctrl_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  in_vld = '0, in_kill = '0, in_nosrc = '0;
  logic [31:0] in_data = '0;
  logic [2:0]  dn_blk = '0, dn_unblk = '0;
  logic        squash = 1'b0, hold = 1'b0;
  logic [1:0]  out_vld, out_rdy;
  logic [15:0] out_data;
  logic        up_blk, up_unblk, ovf;
  logic [2:0]  state, stall, cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  stage_skid_ctrl #(.IN_W(4), .OUT_W(2), .DW(8), .FETCH_DLY(1)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_vld_i(in_vld), .in_kill_i(in_kill), .in_nosrc_i(in_nosrc), .in_data_i(in_data),
    .dn_blk_i(dn_blk), .dn_unblk_i(dn_unblk), .squash_i(squash), .squash_hold_i(hold),
    .out_vld_o(out_vld), .out_rdy_o(out_rdy), .out_data_o(out_data),
    .up_blk_o(up_blk), .up_unblk_o(up_unblk), .state_o(state),
    .stall_o(stall), .skid_cnt_o(cnt), .skid_ovf_o(ovf)
  );

  typedef struct packed {
    logic [3:0]  vld, kill, nos;
    logic [31:0] dat;
    logic [2:0]  blk, ublk;
    logic        sq, hold;
    logic [1:0]  eov, erdy;
    logic [15:0] eod;
    logic        eub, euu;
    logic [2:0]  est, ecnt, esf;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t V [NV] = '{
    // 0 R13 R4 R11: idle forwards two words, lane0 no-source
    '{4'b0011,4'b0000,4'b0001,32'h00001211,3'b000,3'b000,1'b0,1'b0, 2'b11,2'b01,16'h1211,1'b0,1'b0,3'd1,3'd0,3'b000,4'd13},
    // 1 R5 R4: killed lane1 skipped, third live word spills, block pulse
    '{4'b1111,4'b0010,4'b0000,32'h24232221,3'b000,3'b000,1'b0,1'b0, 2'b11,2'b00,16'h2321,1'b1,1'b0,3'd2,3'd1,3'b000,4'd5},
    // 2 R7: drain last word, unblock pulse, Running
    '{4'b0000,4'b0000,4'b0000,32'h00000000,3'b000,3'b000,1'b0,1'b0, 2'b01,2'b00,16'h0024,1'b0,1'b1,3'd1,3'd0,3'b000,4'd7},
    // 3 R3: stall from stage 1, three words captured, block pulse
    '{4'b0111,4'b0000,4'b0100,32'h00333231,3'b010,3'b000,1'b0,1'b0, 2'b00,2'b00,16'h0000,1'b1,1'b0,3'd2,3'd3,3'b010,4'd3},
    // 4 R2: flag sticky, no second pulse
    '{4'b0001,4'b0000,4'b0001,32'h00000041,3'b000,3'b000,1'b0,1'b0, 2'b00,2'b00,16'h0000,1'b0,1'b0,3'd2,3'd4,3'b010,4'd2},
    // 5 R6: unblocked, head drains, fresh input appended
    '{4'b0011,4'b0000,4'b0000,32'h00005251,3'b000,3'b010,1'b0,1'b0, 2'b11,2'b00,16'h3231,1'b0,1'b0,3'd3,3'd4,3'b000,4'd6},
    // 6 R6 R11: next two in order, both no-source
    '{4'b0000,4'b0000,4'b0000,32'h00000000,3'b000,3'b000,1'b0,1'b0, 2'b11,2'b11,16'h4133,1'b0,1'b0,3'd3,3'd2,3'b000,4'd6},
    // 7 R3: stall while unblocking, no block pulse
    '{4'b0001,4'b0000,4'b0000,32'h00000061,3'b001,3'b000,1'b0,1'b0, 2'b00,2'b00,16'h0000,1'b0,1'b0,3'd2,3'd3,3'b001,4'd3},
    // 8 R2: set and clear together, clear wins, drain resumes
    '{4'b0000,4'b0000,4'b0000,32'h00000000,3'b001,3'b001,1'b0,1'b0, 2'b11,2'b00,16'h5251,1'b0,1'b0,3'd3,3'd1,3'b000,4'd2},
    // 9 R8: squash while unblocking, unblock pulse, buffer emptied
    '{4'b0001,4'b0000,4'b0000,32'h00000071,3'b000,3'b000,1'b1,1'b0, 2'b00,2'b00,16'h0000,1'b0,1'b1,3'd4,3'd0,3'b000,4'd8},
    // 10 R9: hold drops input
    '{4'b0001,4'b0000,4'b0000,32'h00000081,3'b000,3'b000,1'b0,1'b1, 2'b00,2'b00,16'h0000,1'b0,1'b0,3'd4,3'd0,3'b000,4'd9},
    // 11 R10 R11: squashing resumes and forwards same cycle
    '{4'b0011,4'b0000,4'b0010,32'h00009291,3'b000,3'b000,1'b0,1'b0, 2'b11,2'b10,16'h9291,1'b0,1'b0,3'd1,3'd0,3'b000,4'd10},
    // 12 R8: squash beats a new stall, no block pulse
    '{4'b0000,4'b0000,4'b0000,32'h00000000,3'b100,3'b000,1'b1,1'b0, 2'b00,2'b00,16'h0000,1'b0,1'b0,3'd4,3'd0,3'b100,4'd8},
    // 13 R3: stall now takes effect from Squashing, block pulse
    '{4'b0000,4'b0000,4'b0000,32'h00000000,3'b000,3'b000,1'b0,1'b0, 2'b00,2'b00,16'h0000,1'b1,1'b0,3'd2,3'd0,3'b100,4'd3},
    // 14 R7: released with empty buffer, immediate unblock
    '{4'b0000,4'b0000,4'b0000,32'h00000000,3'b000,3'b100,1'b0,1'b0, 2'b00,2'b00,16'h0000,1'b0,1'b1,3'd1,3'd0,3'b000,4'd7}
  };

  task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_in();
    in_vld = '0; in_kill = '0; in_nosrc = '0; in_data = '0;
    dn_blk = '0; dn_unblk = '0; squash = 1'b0; hold = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk(1, {state, cnt, stall, ovf}, {3'd0, 3'd0, 3'b000, 1'b0}, "reset state");
    chk(1, {out_vld, up_blk, up_unblk}, '0, "reset outputs");
    @(posedge clk); #1;
    // R13 stays Idle without input
    chk(13, {58'd0, state}, {58'd0, 3'd0}, "idle hold");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_vld = V[i].vld; in_kill = V[i].kill; in_nosrc = V[i].nos; in_data = V[i].dat;
      dn_blk = V[i].blk; dn_unblk = V[i].ublk; squash = V[i].sq; hold = V[i].hold;
      #1;
      chk(int'(V[i].req), {out_vld, out_rdy, out_data, up_blk, up_unblk},
          {V[i].eov, V[i].erdy, V[i].eod, V[i].eub, V[i].euu}, $sformatf("vec %0d outputs", i));
      @(posedge clk); #1;
      chk(int'(V[i].req), {state, cnt, stall}, {V[i].est, V[i].ecnt, V[i].esf},
          $sformatf("vec %0d state", i));
    end

    // R12 no overflow under the correct handshake above
    chk(12, {63'd0, ovf}, 64'd0, "no overflow");

    // R12 overflow: stall, then two full groups into six entries
    @(negedge clk);
    idle_in(); dn_blk = 3'b001; in_vld = 4'b1111; in_data = 32'ha4a3a2a1;
    @(posedge clk); #1;
    chk(3, {state, cnt}, {3'd2, 3'd4}, "overflow setup");
    @(negedge clk);
    dn_blk = 3'b000; in_vld = 4'b1111; in_data = 32'hb4b3b2b1;
    @(posedge clk); #1;
    chk(12, {cnt, ovf}, {3'd6, 1'b1}, "overflow flagged");
    @(negedge clk);
    idle_in();
    @(posedge clk); #1;
    chk(12, {63'd0, ovf}, {63'd0, 1'b1}, "overflow sticky");

    // R1 asynchronous reset from a dirty state
    @(negedge clk) rst_ni = 1'b0;
    #1;
    chk(1, {state, cnt, stall, ovf}, {3'd0, 3'd0, 3'b000, 1'b0}, "mid-run reset");
    @(negedge clk) rst_ni = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule